// File: doc/BRIEF.md
# Multi-Context Configuration Cache

This block stores configuration words for a small array of processing elements across several independent context planes. Each plane holds a fixed-depth sequence of words for each element. While `run_i` is high, the block walks a word index through the active plane. On every cycle it loads one word per element into a context register, and that register drives the element. The path from storage to the element therefore always ends in a flop.

A host write port fills any plane other than the active one while delivery continues, and each accepted write marks its plane valid. A switch request names a preloaded plane. The switch is applied at the next wrap of the word index, so a configuration that is already resident is never reloaded.

Each stored word carries a compression flag. For a compressed word, the upper half of storage is not read and is delivered as zero. Compressed and full-width words mix freely, and neither costs an extra cycle.

Top module: `ctx_cache`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `ctx_o`, `comp_o`, `valid_o`, `act_plane_o`, `wr_err_o` and `sw_err_o` are all zero.
- R2: When `run_i` is high and the active plane is valid at a clock edge, element p's 32-bit slice `ctx_o[32p+31:32p]` holds, after that edge, the word stored for (active plane, current index, p). The index starts at 0 and steps by one modulo 16 on each edge with `run_i` high.
- R3: On an edge with `run_i` low, or with the active plane not valid, every context slice and `comp_o` become zero (the no-op word). The index holds while `run_i` is low.
- R4: A write (`wr_en_i`) to a plane other than the active one stores the data and its flag at (plane, index, element) in one cycle and sets that plane's bit in `valid_o`. Delivery is not disturbed.
- R5: A write addressed to the active plane leaves storage and `valid_o` unchanged, and `wr_err_o` is high for the one following cycle.
- R6: A switch request to a valid plane is held pending. It is applied on the first edge at which either the index is 15 with `run_i` high, or `run_i` is low. `act_plane_o` shows the new plane after that edge, and delivery resumes from the held index.
- R7: A switch request to a plane whose `valid_o` bit is clear, as it stood before that cycle, is ignored, and `sw_err_o` is high for the one following cycle.
- R8: When a delivered word's stored flag is set, bit p of `comp_o` is 1, the upper 16 bits of the slice are zero, and the lower 16 bits are the stored lower half.
- R9: A new accepted switch request that arrives while another is pending replaces the pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Deliver words and advance the index |
| wr_en_i | input | 1 | Background write strobe |
| wr_plane_i | input | 2 | Plane addressed by the write |
| wr_idx_i | input | 4 | Word index addressed by the write |
| wr_pe_i | input | 2 | Element addressed by the write |
| wr_data_i | input | 32 | Word to store |
| wr_comp_i | input | 1 | Compression flag stored with the word |
| sw_req_i | input | 1 | Switch request strobe |
| sw_plane_i | input | 2 | Target plane of the switch |
| ctx_o | output | 128 | Registered context words, element p in bits 32p+31:32p |
| comp_o | output | 4 | Registered compression flag per element |
| act_plane_o | output | 2 | Active plane |
| valid_o | output | 4 | Plane valid bits |
| wr_err_o | output | 1 | Rejected-write pulse |
| sw_err_o | output | 1 | Rejected-switch pulse |

## Verification
The assertions check the following on every cycle: the index steps or holds with `run_i`, the active plane changes only at a wrap or while stopped and only to a valid plane, no-op words follow idle or invalid cycles, compressed slices carry a zero upper half, and error pulses only follow a request. Whether the right stored word reaches the right element, whether a background write lands without disturbing delivery, and whether a later switch request replaces an earlier one can only be shown by the bench. Its behavioural model tracks storage, valid bits, pending switches and the index, and is compared with every output after every edge.

// File: rtl/ctx_cache_pkg.sv
package ctx_cache_pkg;
  localparam int unsigned CTX_W_DEF  = 32;
  localparam int unsigned HALF_W_DEF = 16;

  function automatic int unsigned sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ctx_plane_store.sv
module ctx_plane_store
  import ctx_cache_pkg::*;
#(
  parameter int unsigned PLANES = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NUM_PE = 4,
  parameter int unsigned CTX_W  = CTX_W_DEF,
  parameter int unsigned HALF_W = HALF_W_DEF,
  localparam int unsigned PL_W  = sel_w(PLANES),
  localparam int unsigned IDX_W = sel_w(DEPTH),
  localparam int unsigned PE_W  = sel_w(NUM_PE),
  localparam int unsigned ENT   = PLANES * DEPTH,
  localparam int unsigned HI_W  = CTX_W - HALF_W
) (
  input  logic                      clk_i,
  input  logic                      wr_ok_i,
  input  logic [PL_W-1:0]           wr_plane_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [PE_W-1:0]           wr_pe_i,
  input  logic [CTX_W-1:0]          wr_data_i,
  input  logic                      wr_comp_i,
  input  logic [PL_W-1:0]           rd_plane_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [NUM_PE*CTX_W-1:0]   rd_word_o,
  output logic [NUM_PE-1:0]         rd_comp_o
);
  logic [PL_W+IDX_W-1:0] wr_addr, rd_addr;
  assign wr_addr = {wr_plane_i, wr_idx_i};
  assign rd_addr = {rd_plane_i, rd_idx_i};

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    logic [HALF_W-1:0] mem_lo [ENT];
    logic [HI_W-1:0]   mem_hi [ENT];
    logic              mem_cf [ENT];
    logic              sel, cf_rd, hi_rd_en;
    logic [HI_W-1:0]   hi_rd;

    assign sel = wr_ok_i && (wr_pe_i == PE_W'(p));

    always_ff @(posedge clk_i) begin
      if (sel) begin
        mem_lo[wr_addr] <= wr_data_i[HALF_W-1:0];
        mem_hi[wr_addr] <= wr_data_i[CTX_W-1:HALF_W];
        mem_cf[wr_addr] <= wr_comp_i;
      end
    end

    // upper half is only read for full-width words
    assign cf_rd    = mem_cf[rd_addr];
    assign hi_rd_en = !cf_rd;
    assign hi_rd    = hi_rd_en ? mem_hi[rd_addr] : '0;

    assign rd_word_o[p*CTX_W +: CTX_W] = {hi_rd, mem_lo[rd_addr]};
    assign rd_comp_o[p] = cf_rd;
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_cache_pkg::*;
#(
  parameter int unsigned PLANES = 4,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PL_W  = sel_w(PLANES),
  localparam int unsigned IDX_W = sel_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic [PL_W-1:0]   wr_plane_i,
  input  logic              sw_req_i,
  input  logic [PL_W-1:0]   sw_plane_i,
  output logic              wr_ok_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PL_W-1:0]   act_o,
  output logic [PLANES-1:0] valid_o,
  output logic              wr_err_o,
  output logic              sw_err_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [PL_W-1:0]   act_q, tgt_q;
  logic              pend_q, wr_err_q, sw_err_q;
  logic [PLANES-1:0] valid_q;
  logic              sw_ok, apply, at_wrap;

  assign wr_ok_o = wr_en_i && (wr_plane_i != act_q);
  assign sw_ok   = sw_req_i && valid_q[sw_plane_i];
  assign at_wrap = (idx_q == IDX_W'(DEPTH - 1));
  assign apply   = pend_q && (!run_i || at_wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      act_q    <= '0;
      tgt_q    <= '0;
      pend_q   <= 1'b0;
      valid_q  <= '0;
      wr_err_q <= 1'b0;
      sw_err_q <= 1'b0;
    end else begin
      if (run_i) idx_q <= (at_wrap) ? '0 : idx_q + IDX_W'(1);
      if (apply) act_q <= tgt_q;
      if (sw_ok) begin
        tgt_q  <= sw_plane_i;
        pend_q <= 1'b1;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
      if (wr_ok_o) valid_q[wr_plane_i] <= 1'b1;
      wr_err_q <= wr_en_i && !wr_ok_o;
      sw_err_q <= sw_req_i && !sw_ok;
    end
  end

  assign idx_o    = idx_q;
  assign act_o    = act_q;
  assign valid_o  = valid_q;
  assign wr_err_o = wr_err_q;
  assign sw_err_o = sw_err_q;

  p_idx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> idx_q == $past(idx_q) + IDX_W'(1));
  p_idx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(idx_q));
  p_wr_err_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i) && ($past(wr_plane_i) == $past(act_q)));
  p_act_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> ($past(!run_i) || $past(idx_q) == IDX_W'(DEPTH - 1)));
  p_act_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> valid_q[act_q]);
  p_sw_err_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_err_o |-> $past(sw_req_i));
endmodule

// File: rtl/ctx_out_reg.sv
module ctx_out_reg
  import ctx_cache_pkg::*;
#(
  parameter int unsigned NUM_PE = 4,
  parameter int unsigned CTX_W  = CTX_W_DEF,
  parameter int unsigned HALF_W = HALF_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    deliver_i,
  input  logic [NUM_PE*CTX_W-1:0] word_i,
  input  logic [NUM_PE-1:0]       comp_i,
  output logic [NUM_PE*CTX_W-1:0] ctx_o,
  output logic [NUM_PE-1:0]       comp_o
);
  for (genvar p = 0; p < NUM_PE; p++) begin : g_reg
    logic [CTX_W-1:0] ctx_q;
    logic             cf_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctx_q <= '0;
        cf_q  <= 1'b0;
      end else if (deliver_i) begin
        ctx_q <= word_i[p*CTX_W +: CTX_W];
        cf_q  <= comp_i[p];
      end else begin
        ctx_q <= '0;
        cf_q  <= 1'b0;
      end
    end

    assign ctx_o[p*CTX_W +: CTX_W] = ctx_q;
    assign comp_o[p] = cf_q;

    p_comp_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cf_q |-> ctx_q[CTX_W-1:HALF_W] == '0);
  end
endmodule

// File: rtl/ctx_cache.sv
module ctx_cache
  import ctx_cache_pkg::*;
#(
  parameter int unsigned PLANES = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NUM_PE = 4,
  parameter int unsigned CTX_W  = CTX_W_DEF,
  parameter int unsigned HALF_W = HALF_W_DEF,
  localparam int unsigned PL_W  = sel_w(PLANES),
  localparam int unsigned IDX_W = sel_w(DEPTH),
  localparam int unsigned PE_W  = sel_w(NUM_PE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    wr_en_i,
  input  logic [PL_W-1:0]         wr_plane_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [PE_W-1:0]         wr_pe_i,
  input  logic [CTX_W-1:0]        wr_data_i,
  input  logic                    wr_comp_i,
  input  logic                    sw_req_i,
  input  logic [PL_W-1:0]         sw_plane_i,
  output logic [NUM_PE*CTX_W-1:0] ctx_o,
  output logic [NUM_PE-1:0]       comp_o,
  output logic [PL_W-1:0]         act_plane_o,
  output logic [PLANES-1:0]       valid_o,
  output logic                    wr_err_o,
  output logic                    sw_err_o
);
  logic                    wr_ok, deliver;
  logic [IDX_W-1:0]        idx;
  logic [PL_W-1:0]         act;
  logic [PLANES-1:0]       valid;
  logic [NUM_PE*CTX_W-1:0] rd_word;
  logic [NUM_PE-1:0]       rd_comp;

  ctx_seq #(.PLANES(PLANES), .DEPTH(DEPTH)) u_seq (
    .clk_i, .rst_ni, .run_i, .wr_en_i, .wr_plane_i, .sw_req_i, .sw_plane_i,
    .wr_ok_o(wr_ok), .idx_o(idx), .act_o(act), .valid_o(valid),
    .wr_err_o, .sw_err_o
  );

  ctx_plane_store #(.PLANES(PLANES), .DEPTH(DEPTH), .NUM_PE(NUM_PE),
                    .CTX_W(CTX_W), .HALF_W(HALF_W)) u_store (
    .clk_i, .wr_ok_i(wr_ok), .wr_plane_i, .wr_idx_i, .wr_pe_i, .wr_data_i,
    .wr_comp_i, .rd_plane_i(act), .rd_idx_i(idx),
    .rd_word_o(rd_word), .rd_comp_o(rd_comp)
  );

  assign deliver = run_i && valid[act];

  ctx_out_reg #(.NUM_PE(NUM_PE), .CTX_W(CTX_W), .HALF_W(HALF_W)) u_out (
    .clk_i, .rst_ni, .deliver_i(deliver), .word_i(rd_word), .comp_i(rd_comp),
    .ctx_o, .comp_o
  );

  assign act_plane_o = act;
  assign valid_o     = valid;

  p_noop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deliver |=> (ctx_o == '0) && (comp_o == '0));
endmodule

// File: tb/ctx_cache_tb.sv
module ctx_cache_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run_i = 1'b0, wr_en_i = 1'b0, wr_comp_i = 1'b0, sw_req_i = 1'b0;
  logic [1:0]   wr_plane_i = '0, wr_pe_i = '0, sw_plane_i = '0;
  logic [3:0]   wr_idx_i = '0;
  logic [31:0]  wr_data_i = '0;
  logic [127:0] ctx_o;
  logic [3:0]   comp_o, valid_o;
  logic [1:0]   act_plane_o;
  logic         wr_err_o, sw_err_o;

  int errors = 0, checks = 0;
  bit done = 0;

  ctx_cache u_dut (.clk_i(clk), .*);

  always #10 clk = ~clk;

  // behavioural model state
  logic [31:0] m_mem [4][16][4];
  bit          m_cf  [4][16][4];
  bit [3:0]    m_valid = '0;
  int          m_act = 0, m_idx = 0, m_tgt = 0;
  bit          m_pend = 0;
  logic [31:0] e_ctx [4];
  bit [3:0]    e_comp = '0;
  bit          e_wr_err = 0, e_sw_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit dlv, ok, apply;
    dlv = run_i && m_valid[m_act];
    for (int p = 0; p < 4; p++) begin
      if (dlv) begin
        e_ctx[p]  = m_cf[m_act][m_idx][p] ? {16'h0, m_mem[m_act][m_idx][p][15:0]}
                                          : m_mem[m_act][m_idx][p];
        e_comp[p] = m_cf[m_act][m_idx][p];
      end else begin
        e_ctx[p] = '0; e_comp[p] = 0;
      end
    end
    ok = sw_req_i && m_valid[sw_plane_i];
    e_sw_err = sw_req_i && !ok;
    apply = m_pend && (!run_i || m_idx == 15);
    e_wr_err = wr_en_i && (int'(wr_plane_i) == m_act);
    if (wr_en_i && int'(wr_plane_i) != m_act) begin
      m_mem[wr_plane_i][wr_idx_i][wr_pe_i] = wr_data_i;
      m_cf[wr_plane_i][wr_idx_i][wr_pe_i]  = wr_comp_i;
      m_valid[wr_plane_i] = 1;
    end
    if (apply) begin m_act = m_tgt; m_pend = 0; end
    if (ok) begin m_tgt = sw_plane_i; m_pend = 1; end
    if (run_i) m_idx = (m_idx + 1) % 16;
  endtask

  task automatic compare();
    for (int p = 0; p < 4; p++)
      chk(e_comp[p] ? "R8 ctx" : (e_ctx[p] == 0 ? "R3/R2 ctx" : "R2 ctx"),
          ctx_o[p*32 +: 32], e_ctx[p]);
    chk("R8 comp", 32'(comp_o), 32'(e_comp));
    chk("R6 act", 32'(act_plane_o), 32'(m_act));
    chk("R4 valid", 32'(valid_o), 32'(m_valid));
    chk("R5 wr_err", 32'(wr_err_o), 32'(e_wr_err));
    chk("R7 sw_err", 32'(sw_err_o), 32'(e_sw_err));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    wr_en_i = 0; sw_req_i = 0;
  endtask

  function automatic logic [31:0] pat(input int pl, input int ix, input int pe);
    return 32'h9E3779B9 * (pl * 64 + ix * 4 + pe + 1) + 32'h1234_5677;
  endfunction

  task automatic wr(input int pl, input int ix, input int pe);
    wr_en_i = 1; wr_plane_i = 2'(pl); wr_idx_i = 4'(ix); wr_pe_i = 2'(pe);
    wr_data_i = pat(pl, ix, pe); wr_comp_i = ((ix + pe) % 4 == 3);
    cyc();
  endtask

  task automatic fill(input int pl);
    for (int ix = 0; ix < 16; ix++)
      for (int pe = 0; pe < 4; pe++) wr(pl, ix, pe);
  endtask

  task automatic sw(input int pl);
    sw_req_i = 1; sw_plane_i = 2'(pl);
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ctx", 32'(ctx_o != 0), 0);
    chk("R1 comp", 32'(comp_o), 0);
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 act", 32'(act_plane_o), 0);
    chk("R1 err", 32'({wr_err_o, sw_err_o}), 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 ctx after release", 32'(ctx_o != 0), 0);

    fill(1);                // R4 while stopped
    wr(0, 2, 1);            // R5 active plane write rejected
    sw(2);                  // R7 invalid target
    sw(1);                  // R6 applies while stopped
    idle(1);
    run_i = 1;
    fill(2);                // R4 background fill during delivery (R2, R8)
    fill(3);
    sw(2);                  // R9: replaced by the next request
    sw(3);
    idle(20);
    chk("R9 later switch wins", 32'(act_plane_o), 32'd3);
    wr(3, 0, 0);            // R5 during run
    run_i = 0;
    idle(3);                // R3 no-op while stopped, index holds
    run_i = 1;
    idle(20);
    sw(0);                  // R7 plane 0 never loaded
    sw(1);
    idle(20);
    wr(3, 5, 2);
    idle(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule